// File: doc/BRIEF.md
# Paged Address Translation Unit

This block sits between a 16-bit processor's memory address register and a 512 KB RAM. It turns a 16-bit logical address into a 19-bit physical address. The RAM is divided into 256 pages of 2 KB. A table of 256 sixteen-bit entries gives the physical page for each slot. A small base register picks one of eight fixed address spaces, each 32 pages (64 KB) long. The table slot used is the base value plus the five upper bits of the logical address. The physical page number comes from that entry's upper byte, and the eleven low address bits pass through unchanged as the offset within the page.

Software loads table entries and the base register through two write ports. These writes only take effect while the processor reports kernel mode, so a user program cannot change its own mapping. A paging-enable input, driven from a control register bit, chooses between the translated address and a zero-extended copy of the logical address. With paging off, only the lowest 64 KB of RAM can be reached.

Top module: `paged_xlate`

## Requirements
- R1: After a synchronous active-low reset, the base register holds 0 and every table entry holds 0. With paging on, every logical address therefore maps to physical page 0, keeping its offset.
- R2: When `paging_en` is 0, `ram_addr` equals `{3'b000, logical_addr}`.
- R3: When `paging_en` is 1, `ram_addr` equals `{E[15:8], logical_addr[10:0]}`. Here E is the table entry at index `base + logical_addr[15:11]`.
- R4: While `kernel_mode` is 1, a `pte_we` pulse stores `pte_wdata` into entry `pte_idx` (0 to 255). The change is visible in translation from the next cycle.
- R5: While `kernel_mode` is 1, a `base_we` pulse loads `base_wdata[7:5]` as the address-space number. The base then equals that number times 32, and `base_wdata[4:0]` is discarded.
- R6: A `pte_we` pulse while `kernel_mode` is 0 leaves the table unchanged.
- R7: A `base_we` pulse while `kernel_mode` is 0 leaves the base register unchanged.
- R8: Bits [7:0] of a table entry have no effect on the translated address.
- R9: Translation is combinational. A change of `logical_addr` or `paging_en` shows on `ram_addr` within the same cycle, with no clock edge needed.
- R10: A table write and a base write in the same cycle both take effect, and the next cycle translates through the new base and the new entry.
- R11: Table and base writes made while `paging_en` is 0 are kept. They apply once paging is switched on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| kernel_mode | input | 1 | 1 when the processor runs privileged code; gates all writes |
| paging_en | input | 1 | Paging enable from the control register |
| logical_addr | input | 16 | Logical address from the processor |
| pte_we | input | 1 | Table entry write strobe |
| pte_idx | input | 8 | Table entry index to write |
| pte_wdata | input | 16 | Entry value; bits [15:8] are the physical page |
| base_we | input | 1 | Base register write strobe |
| base_wdata | input | 8 | Base value; bits [7:5] select the address space |
| ram_addr | output | 19 | Physical RAM address |

## Verification
The hardest case to reach is proving that a refused user-mode write left the state untouched. The table and base register have no read port, so their contents can only be seen through `ram_addr`. The stimulus first gives every entry a distinct physical page. It then points the base at the address space that holds the targeted entry before each user-mode attempt. Afterwards it translates a logical address that lands on that entry, or on a page that differs between spaces. This way any wrongly accepted write changes the output. The top corner, base 224 plus page 31, reaches entry 255, and every space is swept with base values that carry junk in their five low bits.

// File: rtl/xlate_pkg.sv
// Package xlate_pkg
// Shared geometry of the paged translation unit: address, page and entry
// widths. All other widths are derived here so that the modules agree.
package xlate_pkg;
    localparam int LA_W    = 16;               // logical address width
    localparam int OFF_W   = 11;               // byte offset inside a page
    localparam int PAGE_W  = LA_W - OFF_W;     // page number inside a space
    localparam int IDX_W   = 8;                // table index width
    localparam int SPACE_W = IDX_W - PAGE_W;   // address-space selector width
    localparam int ENTRY_W = 16;               // table entry width
    localparam int PPN_W   = 8;                // physical page field width
    localparam int PA_W    = PPN_W + OFF_W;    // physical address width
endpackage

// File: rtl/xl_base_reg.sv
// Module xl_base_reg
// Holds the address-space selector. Only the bits above the page-number
// field of the written value are kept, so the effective base is always a
// multiple of the space size. Assumes the write strobe is a single-cycle
// pulse; writes outside privileged mode are dropped.
module xl_base_reg #(
    parameter int IDX_W  = 8,
    parameter int PAGE_W = 5,
    localparam int SPACE_W = IDX_W - PAGE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic               allow,
    input  logic [IDX_W-1:0]   wdata,
    output logic [SPACE_W-1:0] space_q
);

    // Load the space selector on a permitted write; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            space_q <= '0;
        end else if (we && allow) begin
            space_q <= wdata[IDX_W-1:PAGE_W];
        end
    end

    // R5: a privileged write lands in the selector on the next cycle.
    assert_base_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && allow) |=> (space_q == $past(wdata[IDX_W-1:PAGE_W])));

    // R7: an unprivileged write leaves the selector untouched.
    assert_base_user_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !allow) |=> $stable(space_q));

endmodule

// File: rtl/xl_page_table.sv
// Module xl_page_table
// Register array of translation entries with one write port and one
// combinational read port that returns the physical page field of the
// indexed entry. Assumes a synchronous active-low reset that clears
// every entry; lower entry bits are stored but never read out.
module xl_page_table #(
    parameter int IDX_W   = 8,
    parameter int ENTRY_W = 16,
    parameter int PPN_W   = 8,
    localparam int DEPTH  = 1 << IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic               allow,
    input  logic [IDX_W-1:0]   widx,
    input  logic [ENTRY_W-1:0] wdata,
    input  logic [IDX_W-1:0]   ridx,
    output logic [PPN_W-1:0]   rppn
);

    logic [ENTRY_W-1:0] tbl [DEPTH];

    // Write one entry on a permitted strobe; clear every entry on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                tbl[i] <= '0;
            end
        end else if (we && allow) begin
            tbl[widx] <= wdata;
        end
    end

    // Read the physical page field of the selected entry.
    always_comb begin
        rppn = tbl[ridx][ENTRY_W-1 -: PPN_W];
    end

    // R4: a privileged write stores the full value at the given index.
    assert_pte_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (we && allow) |=> (tbl[$past(widx)] == $past(wdata)));

    // R6: an unprivileged write leaves the addressed entry untouched.
    assert_pte_user_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !allow) |=> (tbl[$past(widx)] == $past(tbl[widx])));

endmodule

// File: rtl/xl_addr_mux.sv
// Module xl_addr_mux
// Forms the RAM address: either the physical page joined with the page
// offset, or the logical address zero-extended when paging is off.
// Purely combinational; assumes the physical address is wider than the
// logical one.
module xl_addr_mux #(
    parameter int LA_W  = 16,
    parameter int OFF_W = 11,
    parameter int PPN_W = 8,
    localparam int PA_W = PPN_W + OFF_W
) (
    input  logic              paging_en,
    input  logic [LA_W-1:0]   logical_addr,
    input  logic [PPN_W-1:0]  ppn,
    output logic [PA_W-1:0]   ram_addr
);

    // Select translated or pass-through address.
    always_comb begin
        if (paging_en) begin
            ram_addr = {ppn, logical_addr[OFF_W-1:0]};
        end else begin
            ram_addr = {{(PA_W-LA_W){1'b0}}, logical_addr};
        end
    end

endmodule

// File: rtl/paged_xlate.sv
// Module paged_xlate
// Top of the paged translation unit. Builds the table index from the
// address-space selector and the page number, looks up the physical
// page and forms the RAM address. Assumes kernel_mode is stable around
// the clock edge at which a write strobe is sampled.
module paged_xlate
    import xlate_pkg::*;
#(
    parameter int P_LA_W    = LA_W,
    parameter int P_OFF_W   = OFF_W,
    parameter int P_IDX_W   = IDX_W,
    parameter int P_ENTRY_W = ENTRY_W,
    parameter int P_PPN_W   = PPN_W,
    localparam int P_PAGE_W  = P_LA_W - P_OFF_W,
    localparam int P_SPACE_W = P_IDX_W - P_PAGE_W,
    localparam int P_PA_W    = P_PPN_W + P_OFF_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 kernel_mode,
    input  logic                 paging_en,
    input  logic [P_LA_W-1:0]    logical_addr,
    input  logic                 pte_we,
    input  logic [P_IDX_W-1:0]   pte_idx,
    input  logic [P_ENTRY_W-1:0] pte_wdata,
    input  logic                 base_we,
    input  logic [P_IDX_W-1:0]   base_wdata,
    output logic [P_PA_W-1:0]    ram_addr
);

    logic [P_SPACE_W-1:0] space_q;
    logic [P_IDX_W-1:0]   tbl_idx;
    logic [P_PPN_W-1:0]   ppn;

    xl_base_reg #(
        .IDX_W  (P_IDX_W),
        .PAGE_W (P_PAGE_W)
    ) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (base_we),
        .allow   (kernel_mode),
        .wdata   (base_wdata),
        .space_q (space_q)
    );

    // Index = base (space * 32) + page number; no carry can occur.
    always_comb begin
        tbl_idx = {space_q, logical_addr[P_LA_W-1:P_OFF_W]};
    end

    xl_page_table #(
        .IDX_W   (P_IDX_W),
        .ENTRY_W (P_ENTRY_W),
        .PPN_W   (P_PPN_W)
    ) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (pte_we),
        .allow (kernel_mode),
        .widx  (pte_idx),
        .wdata (pte_wdata),
        .ridx  (tbl_idx),
        .rppn  (ppn)
    );

    xl_addr_mux #(
        .LA_W  (P_LA_W),
        .OFF_W (P_OFF_W),
        .PPN_W (P_PPN_W)
    ) u_mux (
        .paging_en    (paging_en),
        .logical_addr (logical_addr),
        .ppn          (ppn),
        .ram_addr     (ram_addr)
    );

    // R2: with paging off the RAM address is the zero-extended logical one.
    assert_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !paging_en |-> (ram_addr == {{(P_PA_W-P_LA_W){1'b0}}, logical_addr}));

    // R3: the page offset always reaches the RAM address unchanged.
    assert_offset_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ram_addr[P_OFF_W-1:0] == logical_addr[P_OFF_W-1:0]);

    // R1: straight after reset, translation yields physical page 0.
    assert_reset_page_zero_R1: assert property (@(posedge clk)
        (!$past(rst_n) && rst_n && paging_en) |-> (ram_addr[P_PA_W-1:P_OFF_W] == '0));

endmodule

// File: tb/paged_xlate_tb.sv
`timescale 1ns/1ps
module paged_xlate_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        kernel_mode = 1'b0;
    logic        paging_en = 1'b0;
    logic [15:0] logical_addr = '0;
    logic        pte_we = 1'b0;
    logic [7:0]  pte_idx = '0;
    logic [15:0] pte_wdata = '0;
    logic        base_we = 1'b0;
    logic [7:0]  base_wdata = '0;
    logic [18:0] ram_addr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Behavioural reference state
    logic [15:0] ref_tbl [256];
    int          ref_base = 0;

    paged_xlate u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .kernel_mode  (kernel_mode),
        .paging_en    (paging_en),
        .logical_addr (logical_addr),
        .pte_we       (pte_we),
        .pte_idx      (pte_idx),
        .pte_wdata    (pte_wdata),
        .base_we      (base_we),
        .base_wdata   (base_wdata),
        .ram_addr     (ram_addr)
    );

    always #2.5 clk = ~clk;

    function automatic logic [18:0] expect_addr();
        int idx;
        if (!paging_en) return {3'b000, logical_addr};
        idx = (ref_base + int'(logical_addr[15:11])) % 256;
        return {ref_tbl[idx][15:8], logical_addr[10:0]};
    endfunction

    task automatic check(input string tag);
        logic [18:0] exp_v;
        exp_v = expect_addr();
        checks++;
        if (ram_addr !== exp_v) begin
            errors++;
            $display("FAIL %s: la=%h en=%0d ram_addr=%h expected=%h",
                     tag, logical_addr, paging_en, ram_addr, exp_v);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // One clock: drive at falling edge, compare, then advance the model.
    task automatic step(input logic k, input logic en, input logic [15:0] la,
                        input logic pwe, input logic [7:0] pidx, input logic [15:0] pd,
                        input logic bwe, input logic [7:0] bd, input string tag);
        @(negedge clk);
        kernel_mode = k; paging_en = en; logical_addr = la;
        pte_we = pwe; pte_idx = pidx; pte_wdata = pd;
        base_we = bwe; base_wdata = bd;
        #1 check(tag);
        @(posedge clk);
        if (rst_n && k) begin
            if (pwe) ref_tbl[pidx] = pd;
            if (bwe) ref_base = int'(bd & 8'hE0);
        end
    endtask

    task automatic look(input logic en, input logic [15:0] la, input string tag);
        step(1'b0, en, la, 1'b0, 8'h00, 16'h0000, 1'b0, 8'h00, tag);
    endtask

    function automatic logic [15:0] pattern(input int i);
        logic [7:0] hi;
        hi = 8'((i * 7 + 3) % 256);
        return {hi, ~8'(i)};
    endfunction

    // Watchdog: an expired run is a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) ref_tbl[i] = '0;
        ref_base = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: after reset everything maps to physical page 0
        look(1'b1, 16'h0000, "R1");
        look(1'b1, 16'hFFFF, "R1");
        look(1'b1, 16'h5A5A, "R1");

        // R2: paging off passes the address through
        look(1'b0, 16'h0000, "R2");
        look(1'b0, 16'hFFFF, "R2");
        look(1'b0, 16'h8123, "R2");

        // R4 R8: load every entry, lower byte carries junk
        for (int i = 0; i < 256; i++)
            step(1'b1, 1'b1, 16'(i * 253), 1'b1, 8'(i), pattern(i), 1'b0, 8'h00, "R4");

        // R3 R5: every space, base written with junk low bits, all pages
        for (int s = 0; s < 8; s++) begin
            step(1'b1, 1'b1, 16'h0000, 1'b0, 8'h00, 16'h0000, 1'b1,
                 8'((s << 5) | ((s * 11 + 5) & 31)), "R5");
            for (int p = 0; p < 32; p++)
                look(1'b1, 16'((p << 11) | ((p * 97 + s * 13) & 16'h07FF)), "R3");
        end

        // Top corner: base 224 + page 31 reaches entry 255
        look(1'b1, 16'hFFFF, "R3");
        look(1'b0, 16'hFFFF, "R2");

        // R6: user-mode entry write to the entry currently in view
        step(1'b0, 1'b1, 16'hF800, 1'b1, 8'd255, 16'hABCD, 1'b0, 8'h00, "R6");
        look(1'b1, 16'hF800, "R6");
        look(1'b1, 16'hFC01, "R6");

        // R7: user-mode base write, then pages that differ per space
        step(1'b0, 1'b1, 16'h0800, 1'b0, 8'h00, 16'h0000, 1'b1, 8'h20, "R7");
        look(1'b1, 16'h0800, "R7");
        look(1'b1, 16'h7FFF, "R7");

        // R8: change only the lower byte of an entry in view
        step(1'b1, 1'b1, 16'h1000, 1'b1, 8'd226, {pattern(226)[15:8], 8'h00}, 1'b0, 8'h00, "R8");
        look(1'b1, 16'h1000, "R8");
        step(1'b1, 1'b1, 16'h1000, 1'b1, 8'd226, {pattern(226)[15:8], 8'hFF}, 1'b0, 8'h00, "R8");
        look(1'b1, 16'h1000, "R8");

        // R9: address and enable changes seen within one cycle
        @(negedge clk);
        pte_we = 1'b0; base_we = 1'b0;
        logical_addr = 16'h3456; paging_en = 1'b1;
        #0.5 check("R9");
        logical_addr = 16'hC3A1;
        #0.5 check("R9");
        paging_en = 1'b0;
        #0.5 check("R9");

        // R10: entry and base written in the same cycle
        step(1'b1, 1'b1, 16'h0000, 1'b1, 8'd101, 16'h7E11, 1'b1, 8'h7F, "R10");
        look(1'b1, 16'h2A3B, "R10");
        look(1'b1, 16'h0000, "R10");

        // R11: writes while paging is off, then switch on
        step(1'b1, 1'b0, 16'h4444, 1'b1, 8'd64, 16'h3C00, 1'b1, 8'h40, "R11");
        look(1'b0, 16'h0123, "R11");
        look(1'b1, 16'h0123, "R11");
        look(1'b1, 16'hF9AB, "R11");

        finish_run();
    end

endmodule